// File: doc/BRIEF.md
# Two-Wire Register Slave for a Dual Attenuator

This block is the serial control front end of a two-channel attenuator. It
watches the two-wire bus lines with a fast system clock and finds START and
STOP conditions and SCL edges in the sampled data. It answers one 7-bit device
address: a fixed `0101` prefix followed by the levels of three strap inputs.
It holds three registers: a 6-bit level for channel 0, a 6-bit level for
channel 1, and a 3-bit setup field.

A write carries no register pointer. Each data byte names its own target in
its two high bits, so one transfer may update any mix of registers in any
order. A read returns a fixed rotation (channel 0, channel 1, setup) for as long
as the master acknowledges. Every byte read back has the same layout as a
command byte. A one-cycle strobe marks each register update. A STOP pulse marks
the end of a write that changed something, which starts the save logic. While
that logic reports busy, the device address is not acknowledged.

Top module: `potreg_i2c_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth bit) an address byte whose upper seven bits equal `0101` followed by `addr_pins_i[2:0]`; bit 0 of that byte selects read (1) or write (0).
- R2: After an address byte that does not match, the slave neither acknowledges nor acts on any later byte until the next START; a repeated START with the right address is served.
- R3: While `busy_i` is high when the address byte completes, the slave does not acknowledge it and no register changes.
- R4: While `cs_n_i` is high, bus activity is ignored: no acknowledge, no SDA pull-down, no register change.
- R5: In a write, data byte bits [7:6] select the target: `00` channel 0, `01` channel 1, `10` setup. The matching bit of `wr_stb_o` (bit 0, 1, 2 respectively) pulses for one cycle, in the same cycle the new value appears.
- R6: For a channel target, bits [5:0] become the level. For the setup target, bits [2:0] become `cfg_o` and bits [5:3] have no effect.
- R7: A data byte with bits [7:6] = `11` is acknowledged, but it changes no register and raises no strobe.
- R8: Any number of data bytes may follow one write address, in any order; each is applied in turn.
- R9: A read returns `{00, level0}`, `{01, level1}`, `{10, 000, cfg}` in that order, then starts over with channel 0 after each master ACK.
- R10: A master NACK ends the read: the slave releases SDA, and the next read starts again at channel 0.
- R11: `stop_o` pulses for one cycle after a STOP that ends a write to this device in which at least one register was updated. Reads, reserved-only writes and foreign traffic give no pulse.
- R12: After reset both levels are 63, `cfg_o` is `111`, and SDA is released with no strobes active.
- R13: Data is taken at SCL rising edges. The slave changes its SDA pull-down only after an SCL falling edge, except when a START, a STOP or chip deselect releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| cs_n_i | input | 1 | Active-low bus enable |
| addr_pins_i | input | 3 | Low three bits of the device address |
| busy_i | input | 1 | Save logic busy; suppresses address ACK |
| sda_pull_o | output | 1 | Drive SDA low when high |
| wiper0_o | output | 6 | Channel 0 level |
| wiper1_o | output | 6 | Channel 1 level |
| cfg_o | output | 3 | Setup field |
| wr_stb_o | output | 3 | One-hot register update strobe |
| stop_o | output | 1 | Save request pulse after a changing write |

## Verification
The bench goes after the wrap of the read rotation past the setup byte. A
design that clamped there, or restarted at the wrong register, would return a
stale or repeated byte on the fourth read. It sends the reserved selector and
setup bytes with the unused bits set. A loose decode would corrupt a level or
change the setup bits. It sends command-shaped bytes after a foreign address,
while busy is high and while deselected. Any of these reaching the register
file would show as a changed output or an unexpected ACK. It also checks that
reads and reserved-only writes raise no save pulse, which would otherwise wear
out the storage.

// File: rtl/potreg_pkg.sv
package potreg_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 2;
  localparam int WIPER_W = BYTE_W - SEL_W;
  localparam int CFG_W   = 3;
  localparam int NREG    = 3;
  localparam int PTR_W   = $clog2(NREG);
  localparam logic [3:0] DEV_PREFIX = 4'b0101;

  typedef enum logic [SEL_W-1:0] {
    SEL_W0  = 2'b00,
    SEL_W1  = 2'b01,
    SEL_CFG = 2'b10,
    SEL_RSV = 2'b11
  } sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } st_e;
endpackage

// File: rtl/potreg_line_sync.sv
module potreg_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic cs_n_i,
  output logic en_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh, cs_sh;
  logic         scl_q, sda_q;
  logic         scl_s, sda_s;

  // synchronizer chains, one stage per generate slot
  for (genvar g = 0; g <= TOP; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[0] <= 1'b1;
          sda_sh[0] <= 1'b1;
          cs_sh[0]  <= 1'b1;
        end else begin
          scl_sh[0] <= scl_i;
          sda_sh[0] <= sda_i;
          cs_sh[0]  <= cs_n_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[g] <= 1'b1;
          sda_sh[g] <= 1'b1;
          cs_sh[g]  <= 1'b1;
        end else begin
          scl_sh[g] <= scl_sh[g-1];
          sda_sh[g] <= sda_sh[g-1];
          cs_sh[g]  <= cs_sh[g-1];
        end
      end
    end
  end

  assign scl_s = scl_sh[TOP];
  assign sda_s = sda_sh[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    en_o    = ~cs_sh[TOP];
    sda_o   = sda_s;
    rise_o  = en_o & scl_s & ~scl_q;
    fall_o  = en_o & ~scl_s & scl_q;
    start_o = en_o & scl_s & scl_q & sda_q & ~sda_s;
    stop_o  = en_o & scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/potreg_engine.sv
module potreg_engine
  import potreg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         sda,
  input  logic                         ev_rise,
  input  logic                         ev_fall,
  input  logic                         ev_start,
  input  logic                         ev_stop,
  input  logic [2:0]                   dev_pins,
  input  logic                         busy,
  input  logic [NREG-1:0][BYTE_W-1:0]  rd_bank,
  output logic                         sda_pull,
  output logic                         cmd_vld,
  output logic [BYTE_W-1:0]            cmd_byte,
  output logic                         stop_pulse
);
  st_e               st_q, st_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rnw_q, rnw_n;
  logic              mack_q, mack_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n, ptr_adv;
  logic              pull_q, pull_n;
  logic              dirty_q, dirty_n;
  logic              vld_n, stp_n;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_PREFIX, dev_pins}) && !busy;
  assign ptr_adv  = (ptr_q == PTR_W'(NREG-1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    rnw_n   = rnw_q;
    mack_n  = mack_q;
    ptr_n   = ptr_q;
    pull_n  = pull_q;
    dirty_n = dirty_q;
    vld_n   = 1'b0;
    stp_n   = 1'b0;
    if (!en) begin
      st_n    = ST_IDLE;
      pull_n  = 1'b0;
      dirty_n = 1'b0;
    end else if (ev_start) begin
      st_n   = ST_ADDR;
      cnt_n  = '0;
      pull_n = 1'b0;
    end else if (ev_stop) begin
      st_n    = ST_IDLE;
      pull_n  = 1'b0;
      stp_n   = dirty_q;
      dirty_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WR: begin
          if (ev_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda};
            cnt_n = cnt_q + 1'b1;
          end else if (ev_fall && cnt_q == 4'd8) begin
            if (st_q == ST_WR) begin
              vld_n   = 1'b1;
              dirty_n = dirty_q | (sh_q[BYTE_W-1 -: SEL_W] != SEL_RSV);
              st_n    = ST_WACK;
              pull_n  = 1'b1;
            end else if (addr_hit) begin
              st_n   = ST_AACK;
              pull_n = 1'b1;
              rnw_n  = sh_q[0];
              ptr_n  = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (ev_fall) begin
            cnt_n = '0;
            if (rnw_q) begin
              st_n   = ST_RD;
              sh_n   = rd_bank[ptr_q];
              pull_n = ~rd_bank[ptr_q][BYTE_W-1];
            end else begin
              st_n   = ST_WR;
              pull_n = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (ev_fall) begin
            st_n   = ST_WR;
            cnt_n  = '0;
            pull_n = 1'b0;
          end
        end
        ST_RD: begin
          if (ev_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (ev_fall) begin
            if (cnt_q == 4'd8) begin
              st_n   = ST_RACK;
              pull_n = 1'b0;
            end else begin
              sh_n   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (ev_rise) begin
            mack_n = ~sda;
          end else if (ev_fall) begin
            if (mack_q) begin
              st_n   = ST_RD;
              cnt_n  = '0;
              ptr_n  = ptr_adv;
              sh_n   = rd_bank[ptr_adv];
              pull_n = ~rd_bank[ptr_adv][BYTE_W-1];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rnw_q   <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      dirty_q <= 1'b0;
      cmd_vld <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rnw_q   <= rnw_n;
      mack_q  <= mack_n;
      ptr_q   <= ptr_n;
      pull_q  <= pull_n;
      dirty_q <= dirty_n;
      cmd_vld <= vld_n;
      stop_pulse <= stp_n;
    end
  end

  assign sda_pull = pull_q;
  assign cmd_byte = sh_q;
endmodule

// File: rtl/potreg_regs.sv
module potreg_regs
  import potreg_pkg::*;
#(
  parameter logic [WIPER_W-1:0] WIPER_RST = '1,
  parameter logic [CFG_W-1:0]   CFG_RST   = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_vld,
  input  logic [BYTE_W-1:0]           cmd_byte,
  output logic [WIPER_W-1:0]          wiper0,
  output logic [WIPER_W-1:0]          wiper1,
  output logic [CFG_W-1:0]            cfg,
  output logic [NREG-1:0]             wr_stb,
  output logic [NREG-1:0][BYTE_W-1:0] rd_bank
);
  logic [NREG-1:0] hit;
  sel_e            sel;

  assign sel = sel_e'(cmd_byte[BYTE_W-1 -: SEL_W]);

  always_comb begin
    hit = '0;
    if (cmd_vld) begin
      unique case (sel)
        SEL_W0:  hit[0] = 1'b1;
        SEL_W1:  hit[1] = 1'b1;
        SEL_CFG: hit[2] = 1'b1;
        default: hit    = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper0 <= WIPER_RST;
      wiper1 <= WIPER_RST;
      cfg    <= CFG_RST;
      wr_stb <= '0;
    end else begin
      wr_stb <= hit;
      if (hit[0]) wiper0 <= cmd_byte[WIPER_W-1:0];
      if (hit[1]) wiper1 <= cmd_byte[WIPER_W-1:0];
      if (hit[2]) cfg    <= cmd_byte[CFG_W-1:0];
    end
  end

  always_comb begin
    rd_bank[0] = {SEL_W0, wiper0};
    rd_bank[1] = {SEL_W1, wiper1};
    rd_bank[2] = {SEL_CFG, {(WIPER_W-CFG_W){1'b0}}, cfg};
  end
endmodule

// File: rtl/potreg_i2c_slave.sv
module potreg_i2c_slave
  import potreg_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [WIPER_W-1:0] WIPER_RST   = '1,
  parameter logic [CFG_W-1:0]   CFG_RST     = 3'b111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               cs_n_i,
  input  logic [2:0]         addr_pins_i,
  input  logic               busy_i,
  output logic               sda_pull_o,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [NREG-1:0]    wr_stb_o,
  output logic               stop_o
);
  logic line_en, line_sda, ev_rise, ev_fall, ev_start, ev_stop;
  logic cmd_vld;
  logic [BYTE_W-1:0] cmd_byte;
  logic [NREG-1:0][BYTE_W-1:0] rd_bank;

  potreg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .cs_n_i(cs_n_i),
    .en_o(line_en), .sda_o(line_sda), .rise_o(ev_rise), .fall_o(ev_fall),
    .start_o(ev_start), .stop_o(ev_stop)
  );

  potreg_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(line_en), .sda(line_sda),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .dev_pins(addr_pins_i), .busy(busy_i), .rd_bank(rd_bank),
    .sda_pull(sda_pull_o), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .stop_pulse(stop_o)
  );

  potreg_regs #(.WIPER_RST(WIPER_RST), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .wiper0(wiper0_o), .wiper1(wiper1_o), .cfg(cfg_o),
    .wr_stb(wr_stb_o), .rd_bank(rd_bank)
  );
endmodule

// File: rtl/potreg_i2c_slave_chk.sv
module potreg_i2c_slave_chk
  import potreg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               ev_fall,
  input logic               ev_start,
  input logic               ev_stop,
  input logic               sda_pull,
  input logic [WIPER_W-1:0] wiper0,
  input logic [WIPER_W-1:0] wiper1,
  input logic [CFG_W-1:0]   cfg,
  input logic [NREG-1:0]    wr_stb,
  input logic               stop_pulse
);
  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  p_w0_only_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper0) |-> wr_stb[0]);

  p_w1_only_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper1) |-> wr_stb[1]);

  p_cfg_only_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> wr_stb[2]);

  p_deselect_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_pull);

  p_pull_moves_after_fall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(ev_fall || ev_start || ev_stop || !en));

  p_save_follows_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> $past(ev_stop));
endmodule

bind potreg_i2c_slave potreg_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(line_en), .ev_fall(ev_fall),
  .ev_start(ev_start), .ev_stop(ev_stop), .sda_pull(sda_pull_o),
  .wiper0(wiper0_o), .wiper1(wiper1_o), .cfg(cfg_o),
  .wr_stb(wr_stb_o), .stop_pulse(stop_o)
);

// File: tb/sim_potreg_i2c_slave.sv
`timescale 1ns/1ps
module sim_potreg_i2c_slave;
  localparam int Q = 5;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] DEV = {4'b0101, PINS};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, cs_n = 1'b0, busy = 1'b0;
  logic sda_line;
  logic sda_pull;
  logic [5:0] w0, w1;
  logic [2:0] cfg;
  logic [2:0] stb;
  logic stp;

  int nchk = 0, nfail = 0, stop_cnt = 0, stb_cnt = 0;
  logic [5:0] m_w0 = 6'h3F, m_w1 = 6'h3F;
  logic [2:0] m_cfg = 3'b111;
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  potreg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .cs_n_i(cs_n),
    .addr_pins_i(PINS), .busy_i(busy), .sda_pull_o(sda_pull),
    .wiper0_o(w0), .wiper1_o(w1), .cfg_o(cfg), .wr_stb_o(stb), .stop_o(stp)
  );

  always @(posedge clk) begin
    if (stp) stop_cnt++;
    if (stb != 3'b000) stb_cnt++;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int idx);
    case (idx)
      0: exp_byte = {2'b00, m_w0};
      1: exp_byte = {2'b01, m_w1};
      default: exp_byte = {2'b10, 3'b000, m_cfg};
    endcase
  endfunction

  function automatic void model_apply(input logic [7:0] b);
    case (b[7:6])
      2'b00: m_w0 = b[5:0];
      2'b01: m_w1 = b[5:0];
      2'b10: m_cfg = b[2:0];
      default: ;
    endcase
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic v, output logic r);
    wq(); sda_m = v;
    wq(); scl = 1'b1;
    wq(); r = sda_line;   // sampled in the high phase (R13)
    wq(); scl = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
  endtask

  task automatic do_stop();
    wq(); sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, r);
      b = {b[6:0], r};
    end
    bit_io(~give_ack, r);
  endtask

  task automatic write_txn(input logic [6:0] a, input int n, input logic expect_ack,
                           input string tag);
    logic ack;
    do_start();
    send_byte({a, 1'b0}, ack);
    chk({tag, " address ack"}, {7'd0, ack}, {7'd0, expect_ack});
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk({tag, " data ack"}, {7'd0, ack}, {7'd0, expect_ack});
      if (expect_ack) model_apply(wbuf[i]);
    end
    do_stop();
  endtask

  task automatic read_txn(input int n, input int first_idx, input string tag);
    logic ack;
    logic [7:0] b;
    do_start();
    send_byte({DEV, 1'b1}, ack);
    chk({tag, " R1 read address ack"}, {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk({tag, " R9 read byte"}, b, exp_byte((first_idx + i) % 3));
    end
    chk({tag, " R10 SDA released after NACK"}, {7'd0, sda_pull}, 8'd0);
    do_stop();
  endtask

  task automatic chk_outputs(input string tag);
    chk({tag, " level0"}, {2'b00, w0}, {2'b00, m_w0});
    chk({tag, " level1"}, {2'b00, w1}, {2'b00, m_w1});
    chk({tag, " cfg"}, {5'd0, cfg}, {5'd0, m_cfg});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int sc, s2, n;
    logic ack;
    void'($urandom(32'h1881_5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk_outputs("R12 reset");
    chk("R12 SDA released", {7'd0, sda_pull}, 8'd0);
    chk("R12 no strobe", {5'd0, stb}, 8'd0);

    // R1 R5 single write to level 0, R11 save pulse
    sc = stop_cnt; s2 = stb_cnt;
    wbuf[0] = 8'h15;
    write_txn(DEV, 1, 1'b1, "R1 R5 single");
    chk_outputs("R5 level0 write");
    chk("R5 one strobe", 8'(stb_cnt - s2), 8'd1);
    chk("R11 save pulse after write", 8'(stop_cnt - sc), 8'd1);

    // R8 R6 several bytes, out of order, cfg with bits 5..3 set
    wbuf[0] = 8'hBD; wbuf[1] = 8'h6A; wbuf[2] = 8'h07;
    write_txn(DEV, 3, 1'b1, "R8 multi");
    chk_outputs("R8 R6 multi write");

    // R7 reserved selector: ACKed, nothing changes, no save pulse
    sc = stop_cnt; s2 = stb_cnt;
    wbuf[0] = 8'hFF; wbuf[1] = 8'hC0;
    write_txn(DEV, 2, 1'b1, "R7 reserved");
    chk_outputs("R7 reserved no change");
    chk("R7 no strobe", 8'(stb_cnt - s2), 8'd0);
    chk("R11 no save pulse on reserved", 8'(stop_cnt - sc), 8'd0);

    // R9 rotation with wrap, R11 reads give no pulse
    sc = stop_cnt;
    read_txn(7, 0, "R9 rotate");
    chk("R11 no save pulse on read", 8'(stop_cnt - sc), 8'd0);

    // R10 NACK ends read, next read restarts at channel 0
    read_txn(1, 0, "R10 single");
    read_txn(2, 0, "R10 restart");

    // R2 wrong address: data ignored until next START
    do_start();
    send_byte({DEV ^ 7'b0000011, 1'b0}, ack);
    chk("R2 no ack foreign address", {7'd0, ack}, 8'd0);
    send_byte(8'h00, ack);
    chk("R2 no ack foreign data", {7'd0, ack}, 8'd0);
    chk_outputs("R2 foreign bytes ignored");
    wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
    send_byte({DEV, 1'b0}, ack);
    chk("R2 ack after repeated START", {7'd0, ack}, 8'd1);
    send_byte(8'h41, ack);
    model_apply(8'h41);
    do_stop();
    chk_outputs("R2 served after repeated START");

    // R3 busy blocks address ack
    busy = 1'b1;
    wbuf[0] = 8'h2C;
    write_txn(DEV, 1, 1'b0, "R3 busy");
    busy = 1'b0;
    chk_outputs("R3 busy no change");

    // R4 deselected
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    wbuf[0] = 8'h11; wbuf[1] = 8'h82;
    write_txn(DEV, 2, 1'b0, "R4 deselect");
    chk_outputs("R4 deselect no change");
    cs_n = 1'b0;
    repeat (4) @(negedge clk);

    // random traffic
    for (int t = 0; t < 30; t++) begin
      n = 1 + int'($urandom_range(0, 3));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      if ($urandom_range(0, 4) == 0)
        write_txn(DEV ^ 7'(1 + $urandom_range(0, 6)), n, 1'b0, "R2 random foreign");
      else
        write_txn(DEV, n, 1'b1, "R5 R8 random");
      chk_outputs("R6 random");
      if (t % 10 == 9) read_txn(4, 0, "R9 random readback");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule